// File: doc/BRIEF.md
# Wait/Stop Power Sequencer

This block sequences the two sleep depths of a small processor core. A one-cycle request from the instruction decoder puts the core into a shallow sleep or a deep sleep. In shallow sleep only the core clock is gated, and the interrupt controller and host port stay clocked. In deep sleep the oscillator enable is dropped as well, so every clock stops. The sequencer itself runs on an always-on reference clock.

Each depth has its own set of wake sources. Shallow sleep ends on an unmasked interrupt flag, the reset pin or the debug request pin. Deep sleep ends only on the external interrupt pin, the reset pin or the debug request pin. The three pins are active low and pass through a two-flop synchronizer. On a deep-sleep exit the oscillator restarts first. A loadable down-counter then holds both clocks off for the stabilization interval. When the clocks return, the block reports the exit cause with a one-cycle strobe.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, all three enables are 1, `exit_valid` is 0 and the stabilization value is 64.
- R2: In shallow sleep (entered one cycle after `wait_req`), `core_clk_en`=0, `peri_clk_en`=1 and `osc_en`=1.
- R3: Shallow sleep ends on `irq_unmasked`, a low `rst_pin_n` or a low `dbg_pin_n`. A low `irq_pin_n` alone leaves the core asleep.
- R4: In deep sleep (entered one cycle after `stop_req`), all three enables are 0.
- R5: Deep sleep ends on a low `irq_pin_n`, `rst_pin_n` or `dbg_pin_n`. `irq_unmasked` alone leaves all enables at 0.
- R6: A pin goes low before clock edge k. The sequencer acts on it at edge k+2. On a deep-sleep exit, `osc_en` rises at that edge while the core and peripheral clocks stay off. With stabilization value D, `core_clk_en` and `peri_clk_en` rise together D+1 cycles later.
- R7: `exit_cause` is 2'b11 for reset, 2'b10 for debug and 2'b01 for interrupt service. When several sources are seen in the same cycle, the priority is reset over debug over interrupt.
- R8: On a deep-sleep exit caused by the interrupt pin, the cause is 2'b01 if `irq_pending` is 1 in the cycle the clocks return, and 2'b00 (resume) otherwise.
- R9: `exit_valid` is high for exactly one cycle, in the first cycle in which `core_clk_en` is back to 1.
- R10: A pulse on `stab_load` captures `stab_value`. Every later deep-sleep exit uses that value as D.
- R11: When `stop_req` and `wait_req` arrive together, the deep sleep is taken. A sleep request made while already asleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| wait_req | input | 1 | Shallow-sleep request pulse |
| stop_req | input | 1 | Deep-sleep request pulse |
| irq_unmasked | input | 1 | Unmasked interrupt present (synchronous) |
| irq_pending | input | 1 | Arbitration result: an interrupt is still pending |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| dbg_pin_n | input | 1 | Debug request pin, active low, asynchronous |
| stab_load | input | 1 | Capture a new stabilization value |
| stab_value | input | STAB_W | Stabilization value D |
| core_clk_en | output | 1 | Core clock enable |
| peri_clk_en | output | 1 | Interrupt controller / host port clock enable |
| osc_en | output | 1 | Oscillator enable |
| exit_valid | output | 1 | One-cycle exit strobe |
| exit_cause | output | 2 | 00 resume, 01 interrupt, 10 debug, 11 reset |

## Verification
The bench sweeps every mix of wake sources in both sleep depths. A design that shared one wake set between the depths would either wake from deep sleep on the unmasked flag or wake from shallow sleep on the raw interrupt pin. When several sources arrive in the same cycle, an inverted priority shows up as the wrong 2-bit cause. Deep-sleep exits are timed for a zero, small and default stabilization value. An off-by-one counter, or clocks returning before the oscillator, shows up as a shifted rising edge. The bench also clears the pending flag at arbitration time, which catches a design that reports interrupt service instead of falling back to resume.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STOP = 2'd2,
    ST_STAB = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    CAUSE_RESUME = 2'b00,
    CAUSE_IRQ    = 2'b01,
    CAUSE_DEBUG  = 2'b10,
    CAUSE_RESET  = 2'b11
  } exit_cause_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_n,
  output logic [N_PINS-1:0] asserted
);
  logic [N_PINS-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= ~pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign asserted = stage_q[STAGES-1];
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int W       = 8,
  parameter int DEFAULT = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_load,
  input  logic [W-1:0] cfg_val,
  input  logic         start,
  output logic         done
);
  localparam logic [W-1:0] DEF_VAL = W'(DEFAULT);

  logic [W-1:0] cfg_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= DEF_VAL;
    else if (cfg_load) cfg_q <= cfg_val;
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (start)       cnt_q <= cfg_q;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R6: the count holds at zero and never wraps
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) == '0 && !$past(start)) |-> cnt_q == '0);

  // R10: a captured value survives until the next capture
  a_r10_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_load) |-> $stable(cfg_q));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       irq_unmasked,
  input  logic       irq_pending,
  input  logic       wake_rst,
  input  logic       wake_dbg,
  input  logic       wake_irq,
  input  logic       stab_done,
  output logic       stab_start,
  output logic       core_en,
  output logic       peri_en,
  output logic       osc_en,
  output logic       exit_valid,
  output logic [1:0] exit_cause
);
  pwr_state_e  state_q, state_n;
  exit_cause_e hold_q, hold_n, cause_n;
  logic        fire;

  always_comb begin
    state_n    = state_q;
    hold_n     = hold_q;
    cause_n    = CAUSE_RESUME;
    fire       = 1'b0;
    stab_start = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req)      state_n = ST_STOP;
        else if (wait_req) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (wake_rst) begin
          fire = 1'b1; cause_n = CAUSE_RESET;
        end else if (wake_dbg) begin
          fire = 1'b1; cause_n = CAUSE_DEBUG;
        end else if (irq_unmasked) begin
          fire = 1'b1; cause_n = CAUSE_IRQ;
        end
        if (fire) state_n = ST_RUN;
      end
      ST_STOP: begin
        if (wake_rst)      hold_n = CAUSE_RESET;
        else if (wake_dbg) hold_n = CAUSE_DEBUG;
        else if (wake_irq) hold_n = CAUSE_IRQ;
        if (wake_rst || wake_dbg || wake_irq) begin
          state_n    = ST_STAB;
          stab_start = 1'b1;
        end
      end
      ST_STAB: begin
        if (stab_done) begin
          state_n = ST_RUN;
          fire    = 1'b1;
          cause_n = (hold_q == CAUSE_IRQ && !irq_pending) ? CAUSE_RESUME : hold_q;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      hold_q     <= CAUSE_RESUME;
      core_en    <= 1'b1;
      peri_en    <= 1'b1;
      osc_en     <= 1'b1;
      exit_valid <= 1'b0;
      exit_cause <= 2'b00;
    end else begin
      state_q    <= state_n;
      hold_q     <= hold_n;
      core_en    <= (state_n == ST_RUN);
      peri_en    <= (state_n == ST_RUN) || (state_n == ST_WAIT);
      osc_en     <= (state_n != ST_STOP);
      exit_valid <= fire;
      exit_cause <= fire ? cause_n : 2'b00;
    end
  end

  a_r4_osc_off_gates_all: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!core_en && !peri_en));

  a_r2_core_needs_peri: assert property (@(posedge clk) disable iff (rst)
    core_en |-> (peri_en && osc_en));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    exit_valid |=> !exit_valid);

  a_r9_strobe_with_clocks: assert property (@(posedge clk) disable iff (rst)
    exit_valid |-> (core_en && peri_en));

  a_r6_osc_before_clocks: assert property (@(posedge clk) disable iff (rst)
    $rose(peri_en) |-> $past(osc_en));

  a_r8_resume_only_without_pending: assert property (@(posedge clk) disable iff (rst)
    (exit_valid && exit_cause == 2'b00) |-> !$past(irq_pending));

  a_r11_no_request_while_asleep: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP && !wake_rst && !wake_dbg && !wake_irq) |=> !osc_en);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int STAB_W       = 8,
  parameter int STAB_DEFAULT = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_req,
  input  logic              stop_req,
  input  logic              irq_unmasked,
  input  logic              irq_pending,
  input  logic              irq_pin_n,
  input  logic              rst_pin_n,
  input  logic              dbg_pin_n,
  input  logic              stab_load,
  input  logic [STAB_W-1:0] stab_value,
  output logic              core_clk_en,
  output logic              peri_clk_en,
  output logic              osc_en,
  output logic              exit_valid,
  output logic [1:0]        exit_cause
);
  localparam int N_WAKE  = 3;
  localparam int IDX_IRQ = 0;
  localparam int IDX_RST = 1;
  localparam int IDX_DBG = 2;

  logic [N_WAKE-1:0] pins_n;
  logic [N_WAKE-1:0] wake_s;
  logic              stab_start;
  logic              stab_done;

  always_comb begin
    pins_n          = '1;
    pins_n[IDX_IRQ] = irq_pin_n;
    pins_n[IDX_RST] = rst_pin_n;
    pins_n[IDX_DBG] = dbg_pin_n;
  end

  wake_sync #(.N_PINS(N_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_n    (pins_n),
    .asserted (wake_s)
  );

  stab_counter #(.W(STAB_W), .DEFAULT(STAB_DEFAULT)) u_stab (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (stab_load),
    .cfg_val  (stab_value),
    .start    (stab_start),
    .done     (stab_done)
  );

  pwr_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wait_req     (wait_req),
    .stop_req     (stop_req),
    .irq_unmasked (irq_unmasked),
    .irq_pending  (irq_pending),
    .wake_rst     (wake_s[IDX_RST]),
    .wake_dbg     (wake_s[IDX_DBG]),
    .wake_irq     (wake_s[IDX_IRQ]),
    .stab_done    (stab_done),
    .stab_start   (stab_start),
    .core_en      (core_clk_en),
    .peri_en      (peri_clk_en),
    .osc_en       (osc_en),
    .exit_valid   (exit_valid),
    .exit_cause   (exit_cause)
  );
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_req = 0, stop_req = 0, irq_unmasked = 0, irq_pending = 0;
  logic irq_pin_n = 1, rst_pin_n = 1, dbg_pin_n = 1;
  logic stab_load = 0;
  logic [SW-1:0] stab_value = '0;
  logic core_clk_en, peri_clk_en, osc_en, exit_valid;
  logic [1:0] exit_cause;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.STAB_W(SW), .STAB_DEFAULT(64)) u0 (
    .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
    .irq_unmasked(irq_unmasked), .irq_pending(irq_pending),
    .irq_pin_n(irq_pin_n), .rst_pin_n(rst_pin_n), .dbg_pin_n(dbg_pin_n),
    .stab_load(stab_load), .stab_value(stab_value),
    .core_clk_en(core_clk_en), .peri_clk_en(peri_clk_en), .osc_en(osc_en),
    .exit_valid(exit_valid), .exit_cause(exit_cause)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    irq_pin_n = 1; rst_pin_n = 1; dbg_pin_n = 1; irq_unmasked = 0;
    repeat (4) tick();
  endtask

  // wake with the reset pin and wait until clocks are back
  task automatic drain();
    rst_pin_n = 0;
    for (int i = 0; i < 300 && !core_clk_en; i++) tick();
    tick();
    settle();
  endtask

  task automatic go_stop();
    stop_req = 1; tick(); stop_req = 0;
    chk("R4 enables in deep sleep", {core_clk_en, peri_clk_en, osc_en}, 0);
  endtask

  // deep-sleep exit; pins: b2 reset, b1 debug, b0 irq
  task automatic stop_case(input int pins, input int pend, input int d);
    int exp_cause;
    go_stop();
    irq_pending = pend[0];
    rst_pin_n = ~pins[2]; dbg_pin_n = ~pins[1]; irq_pin_n = ~pins[0];
    tick(); tick();
    irq_unmasked = 1;
    tick();
    if (pins == 0) begin
      chk("R5 unmasked flag ignored in deep sleep", {core_clk_en, peri_clk_en, osc_en}, 0);
      drain();
      return;
    end
    chk("R6 oscillator first", {core_clk_en, peri_clk_en, osc_en}, 1);
    repeat (d) tick();
    chk("R6 clocks held during stabilization", {core_clk_en, peri_clk_en}, 0);
    tick();
    exp_cause = pins[2] ? 3 : pins[1] ? 2 : (pend != 0) ? 1 : 0;
    chk("R6 clocks back after D+1", {core_clk_en, peri_clk_en}, 3);
    chk("R9 strobe with clocks", exit_valid, 1);
    chk("R7 R8 deep-sleep cause", exit_cause, exp_cause);
    tick();
    chk("R9 strobe one cycle", exit_valid, 0);
    irq_pending = 0;
    settle();
  endtask

  // shallow-sleep exit; w: b3 reset, b2 debug, b1 unmasked flag, b0 irq pin
  task automatic wait_case(input int w);
    int exp_cause;
    wait_req = 1; tick(); wait_req = 0;
    chk("R2 enables in shallow sleep", {core_clk_en, peri_clk_en, osc_en}, 3);
    rst_pin_n = ~w[3]; dbg_pin_n = ~w[2]; irq_pin_n = ~w[0];
    tick(); tick();
    irq_unmasked = w[1];
    tick();
    if ((w & 14) == 0) begin
      chk("R3 irq pin alone ignored in shallow sleep", {core_clk_en, exit_valid}, 0);
      irq_unmasked = 1; tick(); irq_unmasked = 0;
      chk("R3 unmasked flag wakes", exit_cause, 1);
      settle();
      return;
    end
    exp_cause = w[3] ? 3 : w[2] ? 2 : 1;
    chk("R3 shallow-sleep wake", core_clk_en, 1);
    chk("R9 strobe on wake", exit_valid, 1);
    chk("R7 shallow-sleep cause", exit_cause, exp_cause);
    tick();
    chk("R9 strobe one cycle", exit_valid, 0);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    chk("R1 reset enables", {core_clk_en, peri_clk_en, osc_en}, 7);
    chk("R1 reset strobe", exit_valid, 0);
    tick();

    // R1: default delay of 64
    stop_case(1, 1, 64);

    for (int w = 0; w < 16; w++) wait_case(w);

    // R10: reload the delay, then sweep every pin mix and pending value
    for (int di = 0; di < 3; di++) begin
      int d;
      d = (di == 0) ? 0 : (di == 1) ? 2 : 5;
      stab_value = SW'(d); stab_load = 1; tick(); stab_load = 0; tick();
      for (int p = 0; p < 8; p++)
        for (int pend = 0; pend < 2; pend++) stop_case(p, pend, d);
    end

    // R11: both requests at once take deep sleep; wait request while asleep ignored
    wait_req = 1; stop_req = 1; tick(); wait_req = 0; stop_req = 0;
    chk("R11 stop wins", osc_en, 0);
    wait_req = 1; tick(); wait_req = 0; tick();
    chk("R11 request while asleep ignored", {core_clk_en, peri_clk_en, osc_en}, 0);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule